// File: doc/BRIEF.md
# Mailbox Request Sequencer and Response Checker

This block is the requesting side of a 256-bit shared mailbox that is reached over a simple register bus. A command either opens a control channel or closes it. Either kind can carry a flag that asks the far side to reset the requester as part of the operation. An open command also carries four physical queue addresses (event, completion, receive and send) and an interrupt vector number.

The engine first reads the mailbox control word until the far side has released it. For an open command it then checks the arguments. It packs the page-frame numbers, the vector and a header into eight 32-bit words and writes them out. A close command writes the header word only. The engine then polls the control word again, with a bounded number of attempts and a fixed pause between attempts, until the far side hands the mailbox back. Last, it checks the returned header and reports one result code with a single-cycle done pulse.

Top module: `mbox_req_engine`

## Requirements
- R1: After reset, `busy`, `done` and `bus_req` are low.
- R2: Before writing anything, the engine reads word 7 until bit 31 of the read data is clear. Consecutive reads of word 7 are separated by at least WAIT_CYCLES clock cycles. In this pre-send phase a read of 0xFFFFFFFF counts as held, whatever the reset flag is.
- R3: If POLL_LIMIT reads in a row in one polling phase all find the mailbox held, the engine issues no further access and finishes with result 1 (timeout).
- R4: An open command finishes with result 2 (invalid argument) and writes nothing if any address has a nonzero bit below PAGE_SHIFT, or if the vector has any bit set at position 16 or above.
- R5: Open message layout, with words little-endian (word i is bits 32i+31..32i of the 256-bit message). The 48-bit low parts of the EQ, CQ, RQ and SQ frame numbers (address >> PAGE_SHIFT, 52 bits) sit at bits 0, 48, 96 and 144. Their 4-bit high parts sit at bits 192, 196, 200 and 204. The vector is in bits 223..208.
- R6: Header word 7 has type in bits 2..0 (1 = open, 2 = close), version 0 in bits 5..3, direction 0 in bit 7 and the reset flag in bit 24. All other bits are 0.
- R7: An open command writes words 0 to 7 in ascending order. A close command writes only word 7.
- R8: A response whose bit 31 is clear is accepted with result 0 only if its type equals the request type, its version (bits 5..3) is not above the request version 0, its direction bit 7 is 1 and its status (bits 15..8) is 0. Any other such response gives result 3 (protocol error).
- R9: When the reset flag was set, a read of 0xFFFFFFFF during response polling ends the command at once with result 0. Without the flag the same value counts as held.
- R10: `done` is high for exactly one cycle per command, and `result` is valid in that cycle. `busy` is high from the cycle after the command is accepted until `done`. While `busy` is high, `cmd_valid` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_destroy | input | 1 | 1 = close command, 0 = open command |
| cmd_reset_vf | input | 1 | Ask the far side to reset the requester |
| cmd_eq_addr | input | ADDR_W | Event queue physical address |
| cmd_cq_addr | input | ADDR_W | Completion queue physical address |
| cmd_rq_addr | input | ADDR_W | Receive queue physical address |
| cmd_sq_addr | input | ADDR_W | Send queue physical address |
| cmd_vector | input | VEC_W | Interrupt vector number |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 timeout, 2 invalid argument, 3 protocol error |
| bus_req | output | 1 | Register access request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 3 | Mailbox word index |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | One-cycle access acknowledge |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |

## Verification
The bench aims at the word boundaries of the frame packing: random 52-bit frame numbers have their high nibble and their low 48 bits laid across word edges, so an engine that misplaced a nibble or slipped a low part by one byte would write the wrong words. It drives responses that are wrong in exactly one field, including version 1 against a request of version 0, which an engine with a reversed comparison would accept. It returns the all-ones value with and without the reset flag, so an engine that honoured that value in the wrong phase would either hang until timeout or skip the check. It holds the mailbox for exactly POLL_LIMIT reads to catch an off-by-one attempt count, and it fires a second command while busy, which a leaky engine would act on.

// File: rtl/mbox_req_pkg.sv
package mbox_req_pkg;
   typedef enum logic [1:0] {
      RES_OK      = 2'd0,
      RES_TIMEOUT = 2'd1,
      RES_BADARG  = 2'd2,
      RES_PROTO   = 2'd3
   } res_e;

   localparam int MSG_WORDS = 8;
   localparam int WORD_W    = 32;
   localparam int IDX_W     = $clog2(MSG_WORDS);
   localparam int MSG_W     = MSG_WORDS * WORD_W;
   localparam int FRAME_W   = 52;
   localparam int LOW_W     = 48;
   localparam int HI_W      = FRAME_W - LOW_W;
   localparam int NQ        = 4;
   localparam int NIB_BASE  = NQ * LOW_W;
   localparam int VEC_BASE  = NIB_BASE + NQ * HI_W;
   localparam logic [IDX_W-1:0] CTRL_IDX = IDX_W'(MSG_WORDS - 1);

   localparam logic [2:0] KIND_OPEN  = 3'd1;
   localparam logic [2:0] KIND_CLOSE = 3'd2;
   localparam logic [2:0] REQ_VER    = 3'd0;

   function automatic logic [WORD_W-1:0] make_hdr(input logic [2:0] kind, input logic rst_flag);
      logic [WORD_W-1:0] h;
      h       = '0;
      h[2:0]  = kind;
      h[5:3]  = REQ_VER;
      h[7]    = 1'b0;
      h[24]   = rst_flag;
      return h;
   endfunction
endpackage

// File: rtl/mbox_msg_packer.sv
module mbox_msg_packer
   import mbox_req_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int PAGE_SHIFT = 12,
   parameter int VEC_W      = 32
) (
   input  logic [NQ-1:0][ADDR_W-1:0] q_addr,
   input  logic [VEC_W-1:0]          vector,
   input  logic                      is_close,
   input  logic                      rst_flag,
   input  logic [IDX_W-1:0]          word_idx,
   output logic [WORD_W-1:0]         word,
   output logic                      args_ok
);
   localparam int USED_W = PAGE_SHIFT + FRAME_W;

   if (ADDR_W != USED_W) begin : g_bad_addr
      $error("ADDR_W must equal PAGE_SHIFT + 52");
   end
   if (PAGE_SHIFT < 1) begin : g_bad_shift
      $error("PAGE_SHIFT must be at least 1");
   end
   if (VEC_W < 16) begin : g_bad_vec
      $error("VEC_W must be at least 16");
   end

   logic [MSG_W-1:0] msg;
   logic [NQ-1:0]    aligned;
   logic             vec_ok;

   for (genvar q = 0; q < NQ; q++) begin : g_frame
      logic [FRAME_W-1:0] frame;
      assign frame      = q_addr[q][ADDR_W-1:PAGE_SHIFT];
      assign aligned[q] = (q_addr[q][PAGE_SHIFT-1:0] == '0);
      assign msg[q*LOW_W +: LOW_W]         = frame[LOW_W-1:0];
      assign msg[NIB_BASE + q*HI_W +: HI_W] = frame[FRAME_W-1:LOW_W];
   end

   if (VEC_W > 16) begin : g_vec_wide
      assign vec_ok = (vector[VEC_W-1:16] == '0);
   end else begin : g_vec_exact
      assign vec_ok = 1'b1;
   end

   assign msg[VEC_BASE +: 16] = vector[15:0];
   assign msg[MSG_W-1 -: WORD_W] = make_hdr(is_close ? KIND_CLOSE : KIND_OPEN, rst_flag);

   assign word    = msg[word_idx*WORD_W +: WORD_W];
   assign args_ok = is_close | (vec_ok & (&aligned));
endmodule

// File: rtl/mbox_rsp_check.sv
module mbox_rsp_check
   import mbox_req_pkg::*;
(
   input  logic [WORD_W-1:0] rdata,
   input  logic [2:0]        exp_kind,
   input  logic              wipe_ok,
   output logic              held,
   output logic              wiped,
   output logic              good
);
   assign wiped = wipe_ok && (rdata == '1);
   assign held  = !wiped && rdata[WORD_W-1];
   assign good  = (rdata[2:0] == exp_kind) && (rdata[5:3] <= REQ_VER) &&
                  rdata[7] && (rdata[15:8] == 8'd0);
endmodule

// File: rtl/mbox_wait_timer.sv
module mbox_wait_timer #(
   parameter int WAIT_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   output logic expired
);
   localparam int CW = $clog2(WAIT_CYCLES + 1);

   if (WAIT_CYCLES < 1) begin : g_bad_wait
      $error("WAIT_CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt;
   logic          run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         run <= 1'b0;
      end else if (arm) begin
         cnt <= CW'(WAIT_CYCLES - 1);
         run <= 1'b1;
      end else if (run) begin
         if (cnt == '0) run <= 1'b0;
         else           cnt <= cnt - 1'b1;
      end
   end

   assign expired = run && (cnt == '0);

   // R2
   arm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) arm |-> !run);
endmodule

// File: rtl/mbox_req_engine.sv
module mbox_req_engine
   import mbox_req_pkg::*;
#(
   parameter int ADDR_W      = 64,
   parameter int PAGE_SHIFT  = 12,
   parameter int VEC_W       = 32,
   parameter int POLL_LIMIT  = 20000,
   parameter int WAIT_CYCLES = 250000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_destroy,
   input  logic              cmd_reset_vf,
   input  logic [ADDR_W-1:0] cmd_eq_addr,
   input  logic [ADDR_W-1:0] cmd_cq_addr,
   input  logic [ADDR_W-1:0] cmd_rq_addr,
   input  logic [ADDR_W-1:0] cmd_sq_addr,
   input  logic [VEC_W-1:0]  cmd_vector,
   output logic              busy,
   output logic              done,
   output logic [1:0]        result,
   output logic              bus_req,
   output logic              bus_we,
   output logic [2:0]        bus_addr,
   output logic [31:0]       bus_wdata,
   input  logic              bus_ack,
   input  logic [31:0]       bus_rdata
);
   localparam int TRY_W = $clog2(POLL_LIMIT + 1);

   if (POLL_LIMIT < 1) begin : g_bad_limit
      $error("POLL_LIMIT must be at least 1");
   end

   typedef enum logic [1:0] {S_IDLE, S_READ, S_GAP, S_WRITE} st_e;

   st_e                       st;
   logic                      rsp_phase;
   logic                      close_q;
   logic                      rflag_q;
   logic [NQ-1:0][ADDR_W-1:0] addr_q;
   logic [VEC_W-1:0]          vec_q;
   logic [IDX_W-1:0]          widx;
   logic [TRY_W-1:0]          tries;
   res_e                      res_q;
   logic                      done_q;

   logic [WORD_W-1:0] pk_word;
   logic              args_ok;
   logic              held, wiped, good;
   logic              arm, expired;

   mbox_msg_packer #(
      .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .VEC_W(VEC_W)
   ) u_pack (
      .q_addr(addr_q), .vector(vec_q), .is_close(close_q), .rst_flag(rflag_q),
      .word_idx(widx), .word(pk_word), .args_ok(args_ok)
   );

   mbox_rsp_check u_chk (
      .rdata(bus_rdata), .exp_kind(close_q ? KIND_CLOSE : KIND_OPEN),
      .wipe_ok(rflag_q && rsp_phase), .held(held), .wiped(wiped), .good(good)
   );

   mbox_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_tmr (
      .clk(clk), .rst_n(rst_n), .arm(arm), .expired(expired)
   );

   assign arm = (st == S_READ) && bus_ack && held && (tries != TRY_W'(POLL_LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         rsp_phase <= 1'b0;
         close_q   <= 1'b0;
         rflag_q   <= 1'b0;
         addr_q    <= '0;
         vec_q     <= '0;
         widx      <= '0;
         tries     <= '0;
         res_q     <= RES_OK;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st)
            S_IDLE: if (cmd_valid) begin
               close_q   <= cmd_destroy;
               rflag_q   <= cmd_reset_vf;
               addr_q    <= {cmd_sq_addr, cmd_rq_addr, cmd_cq_addr, cmd_eq_addr};
               vec_q     <= cmd_vector;
               rsp_phase <= 1'b0;
               tries     <= '0;
               st        <= S_READ;
            end
            S_READ: if (bus_ack) begin
               if (held) begin
                  if (tries == TRY_W'(POLL_LIMIT - 1)) begin
                     res_q  <= RES_TIMEOUT;
                     done_q <= 1'b1;
                     st     <= S_IDLE;
                  end else begin
                     tries <= tries + 1'b1;
                     st    <= S_GAP;
                  end
               end else if (!rsp_phase) begin
                  if (!args_ok) begin
                     res_q  <= RES_BADARG;
                     done_q <= 1'b1;
                     st     <= S_IDLE;
                  end else begin
                     widx <= close_q ? CTRL_IDX : '0;
                     st   <= S_WRITE;
                  end
               end else begin
                  res_q  <= (wiped || good) ? RES_OK : RES_PROTO;
                  done_q <= 1'b1;
                  st     <= S_IDLE;
               end
            end
            S_GAP: if (expired) st <= S_READ;
            S_WRITE: if (bus_ack) begin
               if (widx == CTRL_IDX) begin
                  rsp_phase <= 1'b1;
                  tries     <= '0;
                  st        <= S_READ;
               end else begin
                  widx <= widx + 1'b1;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign busy      = (st != S_IDLE);
   assign done      = done_q;
   assign result    = res_q;
   assign bus_req   = (st == S_READ) || (st == S_WRITE);
   assign bus_we    = (st == S_WRITE);
   assign bus_addr  = (st == S_WRITE) ? widx : CTRL_IDX;
   assign bus_wdata = (st == S_WRITE) ? pk_word : '0;

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
   // R2
   hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we));
   // R10
   busy_bus_chk: assert property (@(posedge clk) disable iff (!rst_n) bus_req |-> busy);
   // R3
   tries_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) tries < TRY_W'(POLL_LIMIT));
   // R10
   idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
endmodule

// File: tb/mbox_req_engine_tb.sv
module mbox_req_engine_tb;
   localparam int ADDR_W = 64;
   localparam int PS     = 12;
   localparam int VEC_W  = 32;
   localparam int LIMIT  = 6;
   localparam int WAITC  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic              cmd_valid = 1'b0, cmd_destroy = 1'b0, cmd_reset_vf = 1'b0;
   logic [ADDR_W-1:0] eq_a = '0, cq_a = '0, rq_a = '0, sq_a = '0;
   logic [VEC_W-1:0]  vec = '0;
   logic              busy, done, bus_req, bus_we, bus_ack;
   logic [1:0]        result;
   logic [2:0]        bus_addr;
   logic [31:0]       bus_wdata, bus_rdata;

   mbox_req_engine #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PS), .VEC_W(VEC_W),
      .POLL_LIMIT(LIMIT), .WAIT_CYCLES(WAITC)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_destroy(cmd_destroy),
      .cmd_reset_vf(cmd_reset_vf), .cmd_eq_addr(eq_a), .cmd_cq_addr(cq_a),
      .cmd_rq_addr(rq_a), .cmd_sq_addr(sq_a), .cmd_vector(vec), .busy(busy),
      .done(done), .result(result), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata));

   int checks = 0, errors = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // far-side model
   logic [31:0] mem7 = 32'h0;
   logic [31:0] rsp_word = 32'h0;
   int own_reads = 0, post_held = 0;
   int rd_cnt = 0, wr_cnt = 0, rd_before_wr = 0, done_cnt = 0;
   int last_rd = -1000, min_gap = 1000;
   logic [2:0]  wa [0:15];
   logic [31:0] wd [0:15];
   logic bus_ack_r = 1'b0;
   logic [31:0] rdata_r = '0;
   assign bus_ack = bus_ack_r;
   assign bus_rdata = rdata_r;

   always @(posedge clk) begin
      bus_ack_r <= bus_req && !bus_ack_r;
      if (done) done_cnt <= done_cnt + 1;
      if (bus_req && !bus_ack_r) begin
         if (bus_we) begin
            if (wr_cnt < 16) begin wa[wr_cnt] <= bus_addr; wd[wr_cnt] <= bus_wdata; end
            if (wr_cnt == 0) rd_before_wr <= rd_cnt;
            wr_cnt <= wr_cnt + 1;
            if (bus_addr == 3'd7) begin mem7 <= rsp_word; own_reads <= post_held; end
         end else begin
            rd_cnt <= rd_cnt + 1;
            if (cyc - last_rd < min_gap) min_gap <= cyc - last_rd;
            last_rd <= cyc;
            if (own_reads > 0) begin rdata_r <= 32'h8000_0000; own_reads <= own_reads - 1; end
            else rdata_r <= mem7;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] hdr(input bit close, input bit rf);
      return {7'd0, rf, 16'd0, 8'h00} | (close ? 32'd2 : 32'd1);
   endfunction

   function automatic logic [31:0] exp_word(input int i, input logic [63:0] a0, a1, a2, a3,
                                            input logic [15:0] v, input bit rf);
      logic [255:0] m;
      logic [51:0] f [4];
      f[0] = a0[63:12]; f[1] = a1[63:12]; f[2] = a2[63:12]; f[3] = a3[63:12];
      m = '0;
      for (int q = 0; q < 4; q++) begin
         m[q*48 +: 48]    = f[q][47:0];
         m[192 + q*4 +: 4] = f[q][51:48];
      end
      m[223:208] = v;
      m[255:224] = hdr(1'b0, rf);
      return m[i*32 +: 32];
   endfunction

   task automatic issue(input bit close, input bit rf, input int pre, input int post,
                        input logic [31:0] rsp);
      @(negedge clk);
      mem7 = 32'h0; own_reads = pre; post_held = post; rsp_word = rsp;
      rd_cnt = 0; wr_cnt = 0; rd_before_wr = 0; done_cnt = 0; min_gap = 1000; last_rd = -1000;
      cmd_destroy = close; cmd_reset_vf = rf; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wait_done(output logic [1:0] r);
      int n = 0;
      while (!done && n < 2000) begin @(negedge clk); n++; end
      r = result;
      if (n >= 2000) chk(1'b0, "R10 done never seen", 0, 1);
      repeat (3) @(negedge clk);
   endtask

   task automatic run(input bit close, input bit rf, input int pre, input int post,
                      input logic [31:0] rsp, output logic [1:0] r);
      issue(close, rf, pre, post, rsp);
      wait_done(r);
   endtask

   task automatic check_open_words(input string tag, input bit rf);
      bit ok = (wr_cnt == 8);
      for (int i = 0; i < 8 && i < wr_cnt; i++) begin
         if (wa[i] != 3'(i)) ok = 0;
         if (wd[i] != exp_word(i, eq_a, cq_a, rq_a, sq_a, vec[15:0], rf)) begin
            ok = 0;
            $display("  word %0d got %h exp %h", i, wd[i], exp_word(i, eq_a, cq_a, rq_a, sq_a, vec[15:0], rf));
         end
      end
      chk(ok, tag, wr_cnt, 8);
   endtask

   initial begin
      int wd_lim = 150000;
      while (cyc < wd_lim) @(negedge clk);
      chk(1'b0, "watchdog", cyc, wd_lim);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [1:0] r;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy && !done && !bus_req, "R1 reset outputs", {busy, done, bus_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed open
      eq_a = 64'hF123_4567_89AB_C000; cq_a = 64'h0000_0000_0000_1000;
      rq_a = 64'h8FFF_FFFF_FFFF_F000; sq_a = 64'h5A5A_A5A5_0F0F_0000; vec = 32'h0000_BEEF;
      run(0, 1, 0, 0, 32'h81, r);
      chk(r == 2'd0, "R8 open accepted", r, 0);
      check_open_words("R5 R6 R7 open words", 1);

      // close writes only word 7
      run(1, 0, 0, 1, 32'h82, r);
      chk(r == 2'd0 && wr_cnt == 1 && wa[0] == 3'd7 && wd[0] == hdr(1, 0),
          "R6 R7 close single header word", wd[0], hdr(1, 0));

      // R10 busy high during command
      issue(1, 0, 0, 0, 32'h82);
      chk(busy, "R10 busy after accept", busy, 1);
      wait_done(r);

      // R4 misaligned and wide vector
      cq_a = 64'h0000_0000_0000_1800;
      run(0, 0, 0, 0, 32'h81, r);
      chk(r == 2'd2 && wr_cnt == 0, "R4 misaligned address", r, 2);
      cq_a = 64'h0000_0000_0000_1000; vec = 32'h0001_0000;
      run(0, 0, 0, 0, 32'h81, r);
      chk(r == 2'd2 && wr_cnt == 0, "R4 vector too wide", r, 2);
      vec = 32'h0000_0001;
      run(1, 0, 0, 0, 32'h82, r);
      vec = 32'h0000_0012;

      // R2 pre-poll and gap
      run(0, 0, 2, 0, 32'h81, r);
      chk(r == 2'd0 && rd_before_wr == 3, "R2 reads until owned", rd_before_wr, 3);
      chk(min_gap >= WAITC, "R2 read spacing", min_gap, WAITC);

      // R3 timeout boundary
      run(0, 0, LIMIT, 0, 32'h81, r);
      chk(r == 2'd1 && rd_cnt == LIMIT && wr_cnt == 0, "R3 pre-send timeout", rd_cnt, LIMIT);
      run(0, 0, LIMIT - 1, 0, 32'h81, r);
      chk(r == 2'd0, "R3 last attempt succeeds", r, 0);
      run(0, 0, 0, LIMIT, 32'h81, r);
      chk(r == 2'd1 && rd_cnt == LIMIT + 1, "R3 response timeout", rd_cnt, LIMIT + 1);

      // R8 protocol errors
      run(0, 0, 0, 0, 32'h82, r);
      chk(r == 2'd3, "R8 wrong type", r, 3);
      run(0, 0, 0, 0, 32'h89, r);
      chk(r == 2'd3, "R8 version above request", r, 3);
      run(0, 0, 0, 0, 32'h01, r);
      chk(r == 2'd3, "R8 direction zero", r, 3);
      run(1, 0, 0, 0, 32'h0482, r);
      chk(r == 2'd3, "R8 nonzero status", r, 3);

      // R9 wiped readback
      run(0, 1, 0, 2, 32'hFFFF_FFFF, r);
      chk(r == 2'd0 && rd_cnt == 4, "R9 all-ones with reset flag", r, 0);
      run(1, 0, 0, 0, 32'hFFFF_FFFF, r);
      chk(r == 2'd1, "R9 all-ones without flag held", r, 1);

      // R10 ignore command while busy, one done pulse
      issue(0, 0, 1, 1, 32'h81);
      cmd_destroy = 1'b1; cmd_valid = 1'b1;
      repeat (4) @(negedge clk);
      cmd_valid = 1'b0;
      wait_done(r);
      repeat (10) @(negedge clk);
      chk(done_cnt == 1 && wr_cnt == 8 && r == 2'd0, "R10 busy ignores command", done_cnt, 1);

      // random opens
      for (int k = 0; k < 24; k++) begin
         bit rf = 1'($urandom);
         eq_a = {$urandom, 20'($urandom), 12'h0};
         cq_a = {$urandom, 20'($urandom), 12'h0};
         rq_a = {$urandom, 20'($urandom), 12'h0};
         sq_a = {$urandom, 20'($urandom), 12'h0};
         vec  = {16'h0, 16'($urandom)};
         run(0, rf, $urandom % 3, $urandom % 3, 32'h81, r);
         chk(r == 2'd0, "R8 random open result", r, 0);
         check_open_words("R5 random packing", rf);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule